// File: doc/BRIEF.md
# Password-Protected Power Mode Controller

This block manages the operating mode of a small processor subsystem. Software reaches it through a simple register bus. The block drives three clock enables: one for the CPU, one for the peripherals and one for the whole system. It also drives a clock-divide request together with its divider code, and a system reset request. It supports four modes: active, idle, slow-down and power-down.

Idle gates only the CPU clock, and a pending interrupt ends it. Slow-down asks an external divider to run at the programmed ratio. Power-down stops every clock. Only a selected external wake pin or a hardware reset can end power-down. The slow-down and power-down bits are guarded by a password. Writing one value opens access to them and writing another value closes it again.

Power-down takes effect a fixed number of cycles after the request. Wake-up runs as a timed sequence on the free-running wake clock `clk`. The fast path waits for the regulator and then for the PLL, and returns with all register state held. The reset path continues with flash-ready and boot stages while the system reset is held. It then returns all registers to their defaults and sets a sticky flag that records a wake with reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Writing 0x98 to the password register (address 1) opens protected access, and writing 0xA8 closes it. Any other value leaves access unchanged. Access is closed after reset. Bit 0 of a read from address 1 shows whether access is open.
- R2: In the control register (address 0), bit 1 (slow-down) and bit 2 (power-down) are protected. While access is closed, writes to these two bits are ignored, but the other fields in the same write still take effect.
- R3: Writing 1 to control bit 0 clears `cpu_clk_en` from the next cycle on, while `per_clk_en` and `sys_clk_en` stay high. When `irq_pend` is high during idle, `cpu_clk_en` returns one cycle later.
- R4: Control bit 1 drives `div_req`. The divider register (address 2, bits 3:0) drives `div_code` and is not protected.
- R5: After an accepted power-down write, all clock enables stay high for ENTRY_DLY cycles and then all three go low together.
- R6: During power-down, `irq_pend` has no effect. Outside the active mode every bus write is ignored, including writes to the wake configuration.
- R7: The wake-source field (control bits 5:4) selects the pin that can wake the block: 01 selects `pin_ext_int`, 10 selects `pin_ser_rx`, 11 selects either pin, and 00 selects no pin. This field and the wake-type bit are captured when power-down begins.
- R8: A selected pin causes a wake only if it is first seen high during power-down and then stays low for LOW_CYC consecutive cycles. A shorter low pulse is ignored.
- R9: When wake-type (control bit 6) is 0, all enables return together REG_CYC+PLL_CYC cycles after the wake is detected. The slow-down bit, the divider code and the password state are all kept.
- R10: When wake-type is 1, `sys_clk_en` returns after REG_CYC+PLL_CYC cycles. `sys_rst_req` is then held for FLASH_CYC+BOOT_CYC cycles. After that, all enables return, every register goes back to its default, and the wake flag (control bit 7) is set.
- R11: The wake flag is sticky. Writing the control register with bit 7 at 0 clears it, and `por_n` clears it. It survives `hw_rst`.
- R12: A `hw_rst` pulse returns the block to active from any mode and resets every register except the wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_pend | input | 1 | An enabled interrupt is pending |
| pin_ext_int | input | 1 | External interrupt wake pin |
| pin_ser_rx | input | 1 | Serial receive wake pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| sys_clk_en | output | 1 | System clock enable |
| div_req | output | 1 | Slow-down divide request |
| div_code | output | 4 | Divider ratio code |
| sys_rst_req | output | 1 | System reset held during the reset-path wake |

## Verification
Some rules are checked by assertions on every cycle. These are: the slow-down bit stays stable under a closed write, an interrupt ends idle one cycle later, power-down is never left on an interrupt, the CPU and peripheral enables never run without the system enable, the CPU stays stopped while the system reset is held, and the wake flag rises only when a reset-path sequence completes. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle counts of entry and of each wake stage, the sweep over every wake-source code, wake type and falling pin, ignored configuration writes during power-down, rejected short pulses, and the flag's life across hardware reset and software clear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_ACT, ST_IDLE, ST_PD_DLY, ST_PD, ST_W_REG, ST_W_PLL, ST_W_FLASH, ST_W_BOOT
  } pmc_state_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_PASS = 2'd1;
  localparam logic [1:0] ADR_DIV  = 2'd2;

  localparam logic [7:0] PW_OPEN  = 8'h98;
  localparam logic [7:0] PW_CLOSE = 8'hA8;

  localparam int B_IDLE = 0;
  localparam int B_SLOW = 1;
  localparam int B_PD   = 2;
  localparam int B_WRST = 6;
  localparam int B_FLAG = 7;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       active,
  input  logic       idle_st,
  input  logic       pdly_st,
  input  logic       rst_done,
  output logic [7:0] rdata,
  output logic       slow_q,
  output logic [3:0] div_q,
  output logic [1:0] src_q,
  output logic       wrst_q,
  output logic       idle_go,
  output logic       pd_go
);
  logic open_q;
  logic flag_q;
  logic ctrl_wr, pass_wr, div_wr;

  assign ctrl_wr = wr && active && (addr == ADR_CTRL);
  assign pass_wr = wr && active && (addr == ADR_PASS);
  assign div_wr  = wr && active && (addr == ADR_DIV);
  assign pd_go   = ctrl_wr && wdata[B_PD] && open_q;
  assign idle_go = ctrl_wr && wdata[B_IDLE] && !pd_go;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      open_q <= 1'b0;
      slow_q <= 1'b0;
      div_q  <= '0;
      src_q  <= '0;
      wrst_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (hw_rst || rst_done) begin
      open_q <= 1'b0;
      slow_q <= 1'b0;
      div_q  <= '0;
      src_q  <= '0;
      wrst_q <= 1'b0;
      if (rst_done) flag_q <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        src_q  <= wdata[5:4];
        wrst_q <= wdata[B_WRST];
        if (open_q) slow_q <= wdata[B_SLOW];
        if (!wdata[B_FLAG]) flag_q <= 1'b0;
      end
      if (pass_wr) begin
        if (wdata == PW_OPEN) open_q <= 1'b1;
        else if (wdata == PW_CLOSE) open_q <= 1'b0;
      end
      if (div_wr) div_q <= wdata[3:0];
    end
  end

  always_comb begin
    case (addr)
      ADR_CTRL: rdata = {flag_q, wrst_q, src_q, 1'b0, pdly_st, slow_q, idle_st};
      ADR_PASS: rdata = {7'd0, open_q};
      ADR_DIV:  rdata = {4'd0, div_q};
      default:  rdata = 8'd0;
    endcase
  end

  // R2
  slow_guard_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_wr && !open_q && !hw_rst && !rst_done) |=> $stable(slow_q));

  // R11
  flag_origin_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_q) |-> $past(rst_done));
endmodule

// File: rtl/pmc_wake_filter.sv
module pmc_wake_filter #(
  parameter int LOW_CYC = 1
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic en,
  input  logic pin,
  output logic fire
);
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_CYC - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en || clr) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_q | pin;
      if (pin || !armed_q) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign fire = en && armed_q && !pin && (cnt_q == LAST);

  // R8
  single_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> !fire);

  if (LOW_CYC > 1) begin : g_width
    // R8
    low_width_chk: assert property (@(posedge clk) disable iff (!por_n)
      fire |-> $past(!pin));
  end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int ENTRY_DLY = 2,
  parameter int REG_CYC   = 1500,
  parameter int PLL_CYC   = 2000,
  parameter int FLASH_CYC = 1600,
  parameter int BOOT_CYC  = 2500
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst,
  input  logic       idle_go,
  input  logic       pd_go,
  input  logic       irq_pend,
  input  logic       wake_fire,
  input  logic       cfg_wrst,
  input  logic [1:0] cfg_src,
  output pmc_state_e st,
  output logic [1:0] src_lat,
  output logic       rst_done
);
  localparam int M1   = (ENTRY_DLY > REG_CYC) ? ENTRY_DLY : REG_CYC;
  localparam int M2   = (PLL_CYC > FLASH_CYC) ? PLL_CYC : FLASH_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M3 > BOOT_CYC) ? M3 : BOOT_CYC;
  localparam int CW   = $clog2(MAXD + 1);

  pmc_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          path_q;
  logic          cnt_z;

  assign cnt_z = (cnt_q == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q    <= ST_ACT;
      cnt_q   <= '0;
      path_q  <= 1'b0;
      src_lat <= '0;
    end else if (hw_rst) begin
      st_q  <= ST_ACT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_ACT: begin
          if (pd_go) begin
            st_q  <= ST_PD_DLY;
            cnt_q <= CW'(ENTRY_DLY - 1);
          end else if (idle_go) begin
            st_q <= ST_IDLE;
          end
        end
        ST_IDLE: if (irq_pend) st_q <= ST_ACT;
        ST_PD_DLY: begin
          if (!cnt_z) cnt_q <= cnt_q - CW'(1);
          else begin
            st_q    <= ST_PD;
            path_q  <= cfg_wrst;
            src_lat <= cfg_src;
          end
        end
        ST_PD: begin
          if (wake_fire) begin
            st_q  <= ST_W_REG;
            cnt_q <= CW'(REG_CYC - 1);
          end
        end
        ST_W_REG: begin
          if (!cnt_z) cnt_q <= cnt_q - CW'(1);
          else begin
            st_q  <= ST_W_PLL;
            cnt_q <= CW'(PLL_CYC - 1);
          end
        end
        ST_W_PLL: begin
          if (!cnt_z) cnt_q <= cnt_q - CW'(1);
          else if (path_q) begin
            st_q  <= ST_W_FLASH;
            cnt_q <= CW'(FLASH_CYC - 1);
          end else begin
            st_q <= ST_ACT;
          end
        end
        ST_W_FLASH: begin
          if (!cnt_z) cnt_q <= cnt_q - CW'(1);
          else begin
            st_q  <= ST_W_BOOT;
            cnt_q <= CW'(BOOT_CYC - 1);
          end
        end
        ST_W_BOOT: begin
          if (!cnt_z) cnt_q <= cnt_q - CW'(1);
          else st_q <= ST_ACT;
        end
        default: st_q <= ST_ACT;
      endcase
    end
  end

  assign st       = st_q;
  assign rst_done = (st_q == ST_W_BOOT) && cnt_z && !hw_rst;

  // R6
  pd_irq_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_PD && irq_pend && !wake_fire && !hw_rst) |=> (st_q == ST_PD));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int ENTRY_DLY = 2,
  parameter int REG_CYC   = 1500,
  parameter int PLL_CYC   = 2000,
  parameter int FLASH_CYC = 1600,
  parameter int BOOT_CYC  = 2500,
  parameter int LOW_CYC   = 1
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_pend,
  input  logic       pin_ext_int,
  input  logic       pin_ser_rx,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       sys_clk_en,
  output logic       div_req,
  output logic [3:0] div_code,
  output logic       sys_rst_req
);
  localparam int NPIN = 2;

  pmc_state_e      st;
  logic [1:0]      src_q, src_lat;
  logic            wrst_q, slow_q, idle_go, pd_go, rst_done;
  logic [NPIN-1:0] pins, fire_v;

  assign pins = {pin_ser_rx, pin_ext_int};

  pmc_regs u_regs (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .active(st == ST_ACT), .idle_st(st == ST_IDLE), .pdly_st(st == ST_PD_DLY),
    .rst_done(rst_done), .rdata(bus_rdata),
    .slow_q(slow_q), .div_q(div_code), .src_q(src_q), .wrst_q(wrst_q),
    .idle_go(idle_go), .pd_go(pd_go)
  );

  pmc_seq #(
    .ENTRY_DLY(ENTRY_DLY), .REG_CYC(REG_CYC), .PLL_CYC(PLL_CYC),
    .FLASH_CYC(FLASH_CYC), .BOOT_CYC(BOOT_CYC)
  ) u_seq (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst),
    .idle_go(idle_go), .pd_go(pd_go), .irq_pend(irq_pend),
    .wake_fire(|fire_v), .cfg_wrst(wrst_q), .cfg_src(src_q),
    .st(st), .src_lat(src_lat), .rst_done(rst_done)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pmc_wake_filter #(.LOW_CYC(LOW_CYC)) u_filt (
      .clk(clk), .por_n(por_n), .clr(hw_rst),
      .en((st == ST_PD) && src_lat[i]),
      .pin(pins[i]), .fire(fire_v[i])
    );
  end

  always_comb begin
    cpu_clk_en  = (st == ST_ACT) || (st == ST_PD_DLY);
    per_clk_en  = cpu_clk_en || (st == ST_IDLE);
    sys_rst_req = (st == ST_W_FLASH) || (st == ST_W_BOOT);
    sys_clk_en  = per_clk_en || sys_rst_req;
  end

  assign div_req = slow_q;

  // R3
  idle_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_IDLE && irq_pend && !hw_rst) |=> (cpu_clk_en && per_clk_en));

  // R5
  clk_tree_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_clk_en |-> (!cpu_clk_en && !per_clk_en));

  // R10
  rst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> !cpu_clk_en);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int E = 2, R = 5, P = 4, F = 3, B = 2, L = 3;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, hw_rst = 1'b0, bus_wr = 1'b0, irq_pend = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] pin_v = 2'b11;
  logic       cpu_en, per_en, sys_en, div_req, rst_req;
  logic [3:0] div_code;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_mode_ctrl #(.ENTRY_DLY(E), .REG_CYC(R), .PLL_CYC(P), .FLASH_CYC(F),
                  .BOOT_CYC(B), .LOW_CYC(L)) i_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pend(irq_pend), .pin_ext_int(pin_v[0]), .pin_ser_rx(pin_v[1]),
    .cpu_clk_en(cpu_en), .per_clk_en(per_en), .sys_clk_en(sys_en),
    .div_req(div_req), .div_code(div_code), .sys_rst_req(rst_req));

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_hw_rst();
    hw_rst = 1'b1;
    tick(1);
    hw_rst = 1'b0;
  endtask

  function automatic int ens();
    return {29'd0, cpu_en, per_en, sys_en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    por_n = 1'b1;
    tick(1);
    // reset state (R12, R1)
    check("R12 reset enables", ens(), 7);
    check("R12 reset div_req", div_req, 0);
    check("R12 reset rst_req", rst_req, 0);
    rd(2'd1, d); check("R1 reset closed", d, 0);
    rd(2'd0, d); check("R11 reset ctrl", d, 0);

    // R2: closed write of slow-down keeps other fields
    wr(2'd0, 8'h32);
    check("R2 closed slow", div_req, 0);
    rd(2'd0, d); check("R2 other fields taken", d, 8'h30);
    wr(2'd0, 8'h04);
    tick(E + 2);
    check("R2 closed pd ignored", ens(), 7);
    // R1 password values
    wr(2'd1, 8'h55); rd(2'd1, d); check("R1 other value", d, 0);
    wr(2'd1, 8'h98); rd(2'd1, d); check("R1 open", d, 1);
    wr(2'd1, 8'h13); rd(2'd1, d); check("R1 other keeps open", d, 1);
    wr(2'd0, 8'h02); check("R4 slow set", div_req, 1);
    wr(2'd1, 8'hA8); rd(2'd1, d); check("R1 close", d, 0);
    wr(2'd0, 8'h00); check("R2 closed clear ignored", div_req, 1);
    wr(2'd2, 8'h0B); check("R4 div code", div_code, 11);
    wr(2'd1, 8'h98); wr(2'd0, 8'h00); wr(2'd1, 8'hA8);
    check("R4 slow cleared", div_req, 0);

    // R3 idle
    wr(2'd0, 8'h01);
    check("R3 idle enables", ens(), 3);
    tick(3);
    check("R3 idle holds", ens(), 3);
    irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
    check("R3 irq exit", ens(), 7);

    // power-down sweep: source x type x falling pin
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 2; t++) begin
        for (int p = 0; p < 2; p++) begin
          bit wake;
          wake = ((s >> p) & 1) == 1;
          wr(2'd1, 8'h98);
          wr(2'd0, {1'b1, t[0], s[1:0], 4'b0110});
          check("R5 entry window", ens(), 7);
          tick(E - 1);
          check("R5 entry window end", ens(), 7);
          tick(1);
          check("R5 all off", ens(), 0);
          tick(1);
          irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
          check("R6 irq in pd", ens(), 0);
          wr(2'd0, {1'b1, ~t[0], ~s[1:0], 4'b0100});
          wr(2'd1, 8'hA8);
          if (wake) begin
            pin_v[p] = 1'b0; tick(L - 1); pin_v[p] = 1'b1;
            tick(2);
            check("R8 short pulse", ens(), 0);
          end
          pin_v[p] = 1'b0;
          tick(L + R + P - 1);
          check("R9 R10 stage wait", sys_en, 0);
          tick(1);
          if (!wake) begin
            check("R7 unselected pin", ens(), 0);
            pin_v[p] = 1'b1;
            pulse_hw_rst();
            check("R12 hw reset from pd", ens(), 7);
          end else if (t == 0) begin
            check("R9 fast wake enables", ens(), 7);
            check("R9 slow kept", div_req, 1);
            rd(2'd1, d); check("R9 password kept", d, 1);
            pin_v[p] = 1'b1;
          end else begin
            check("R10 sys clock only", ens(), 1);
            check("R10 rst req", rst_req, 1);
            tick(F + B - 1);
            check("R10 cpu held", cpu_en, 0);
            tick(1);
            check("R10 reset wake enables", ens(), 7);
            check("R10 rst req end", rst_req, 0);
            rd(2'd0, d); check("R10 ctrl with flag", d, 8'h80);
            check("R10 div reset", div_code, 0);
            check("R10 slow reset", div_req, 0);
            pin_v[p] = 1'b1;
          end
          tick(2);
        end
      end
    end

    // R11 / R12: flag survives hw_rst, cleared by write of 0
    wr(2'd0, 8'h81);
    pulse_hw_rst();
    check("R12 hw reset from idle", ens(), 7);
    rd(2'd0, d); check("R11 flag kept", d, 8'h80);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R11 flag cleared", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule